// File: doc/BRIEF.md
# Signed Adder-Subtractor with Decimal Readout

This block takes two small two's-complement operands from switches, A and B, and a mode bit. With the mode bit low it forms B + A. With the mode bit high it forms B − A. It does the subtraction by inverting every bit of A and feeding a carry of one into the bottom of a ripple chain, so a single adder serves both modes.

The adder also reports signed overflow of the operand-width sum. It uses that flag to pick a top bit, which makes the one-bit-wider result exact over the whole range from −8 to +7. The exact result and the overflow flag drive LEDs directly.

The same result also appears in signed decimal on a multiplexed seven-segment display. A refresh counter runs from the free-running clock and enables one digit at a time. The display shows the magnitude, with a minus sign lit on the digit just left of the leading decimal digit. All other digits stay dark.

Top module: `signed_addsub_display`

## Requirements
- R1: With `sub_mode` = 0, `led_result` equals B + A as an exact 4-bit two's-complement value for all 64 operand pairs.
- R2: With `sub_mode` = 1, `led_result` equals B − A as an exact 4-bit two's-complement value for all 64 operand pairs.
- R3: `led_ovf` is 1 exactly when the true result lies outside −4..+3. Equivalently, B and the (possibly inverted) A share a sign and the 3-bit sum has the other sign.
- R4: When overflow is set, bit 3 of `led_result` is the inverse of bit 2 of the 3-bit sum. Otherwise bit 3 equals bit 2 of the 3-bit sum.
- R5: While `rst_n` is low, the scan counter and the digit index are held at zero, so `an_n` reads 4'b1110 (digit 0 enabled).
- R6: Exactly one bit of the active-low `an_n` is low at a time. The enabled digit moves from index i to index i+1 after each REFRESH_DIV clock cycles, and wraps from the last index back to 0. A bench-sized REFRESH_DIV of 2 means two cycles per digit.
- R7: Digit 0 (`an_n[0]`) shows the ones digit of |result|. `seg_n` is active-low with bit 0 = segment a through bit 6 = segment g. The codes are: 0→7'h40, 1→7'h79, 2→7'h24, 3→7'h30, 4→7'h19, 5→7'h12, 6→7'h02, 7→7'h78, 8→7'h00, 9→7'h10. A result of −8 must show 8.
- R8: For a negative result, the digit just left of the leading decimal digit of |result| shows the minus sign 7'h3F (only segment g lit). That is digit 1 for every result in range.
- R9: A digit that carries neither a decimal digit nor the minus sign is blank (`seg_n` = 7'h7F).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for the digit scan |
| rst_n | input | 1 | Asynchronous active-low reset of the scan state |
| op_a | input | 3 | Operand A, two's complement |
| op_b | input | 3 | Operand B, two's complement |
| sub_mode | input | 1 | 0: B + A, 1: B − A |
| led_result | output | 4 | Exact signed result |
| led_ovf | output | 1 | Signed overflow of the 3-bit sum |
| an_n | output | 4 | Active-low digit enables, one low at a time |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} of the enabled digit |

## Verification
The bench sweeps every one of the 64 operand pairs in both modes and holds each pair for a full scan of all four digits. Pairs of two large positives or two large negatives tell a correct overflow repair apart from a truncated 3-bit sum. Subtractions with A = −4 exercise the inverted-and-carried path at its limit. Negative results, including −8 from −4 + −4, separate a proper magnitude and minus placement from a raw binary readout. Zero and positive results confirm that the sign digit stays blank.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  localparam logic [6:0] SEG_MINUS = 7'b1000000;  // active-high, g only
  localparam logic [6:0] SEG_BLANK = 7'b0000000;

  // Active-high segment pattern, bit0 = a ... bit6 = g
  function automatic logic [6:0] seg_of_digit(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'd0: s = 7'b0111111;
      4'd1: s = 7'b0000110;
      4'd2: s = 7'b1011011;
      4'd3: s = 7'b1001111;
      4'd4: s = 7'b1100110;
      4'd5: s = 7'b1101101;
      4'd6: s = 7'b1111101;
      4'd7: s = 7'b0000111;
      4'd8: s = 7'b1111111;
      4'd9: s = 7'b1101111;
      default: s = SEG_BLANK;
    endcase
    return s;
  endfunction

  function automatic int unsigned pow10(input int unsigned k);
    int unsigned p;
    p = 1;
    for (int unsigned i = 0; i < k; i++) p = p * 10;
    return p;
  endfunction

  function automatic logic [3:0] dec_digit(input int unsigned v, input int unsigned place);
    return 4'((v / place) % 10);
  endfunction

  // Magnitude of a two's-complement value; the most negative code maps to 2^(n-1)
  function automatic logic [7:0] abs_of(input logic [7:0] v, input logic neg);
    return neg ? (~v + 8'd1) : v;
  endfunction

endpackage

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int W = 3
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sub_mode,
  output logic [W-1:0] a_eff,
  output logic [W-1:0] sum_raw,
  output logic         ovf,
  output logic [W:0]   result
);
  logic [W:0] carry;

  assign carry[0] = sub_mode;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign a_eff[i]     = op_a[i] ^ sub_mode;
    assign sum_raw[i]   = a_eff[i] ^ op_b[i] ^ carry[i];
    assign carry[i+1]   = (a_eff[i] & op_b[i]) | (carry[i] & (a_eff[i] ^ op_b[i]));
  end

  assign ovf    = carry[W] ^ carry[W-1];
  assign result = {ovf ? ~sum_raw[W-1] : sum_raw[W-1], sum_raw};
endmodule

// File: rtl/dec_display_map.sv
module dec_display_map
  import addsub_pkg::*;
#(
  parameter int W          = 3,
  parameter int NUM_DIGITS = 4
) (
  input  logic [W:0]                  result,
  output logic [NUM_DIGITS-1:0][6:0]  digit_codes,
  output logic                        is_neg
);
  localparam int RW = W + 1;

  logic [7:0]  mag8;
  int unsigned mag;

  assign is_neg = result[W];
  assign mag8   = abs_of(8'(result) | (is_neg ? ~8'((1 << RW) - 1) : 8'd0), is_neg);
  assign mag    = 32'(mag8);

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dig
    localparam int unsigned PL = pow10(k);
    if (k == 0) begin : g_ones
      assign digit_codes[k] = seg_of_digit(dec_digit(mag, 1));
    end else begin : g_upper
      localparam int unsigned PREV = pow10(k - 1);
      always_comb begin
        if (mag >= PL)                   digit_codes[k] = seg_of_digit(dec_digit(mag, PL));
        else if (is_neg && mag >= PREV)  digit_codes[k] = SEG_MINUS;
        else                             digit_codes[k] = SEG_BLANK;
      end
    end
  end
endmodule

// File: rtl/scan_driver.sv
module scan_driver #(
  parameter int NUM_DIGITS  = 4,
  parameter int REFRESH_DIV = 50_000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_DIGITS-1:0][6:0] digit_codes,
  output logic [NUM_DIGITS-1:0]      an_n,
  output logic [6:0]                 seg_n
);
  localparam int CW = (REFRESH_DIV > 1) ? $clog2(REFRESH_DIV) : 1;
  localparam int IW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(REFRESH_DIV - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(NUM_DIGITS - 1);

  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          wrap;
  logic          last_digit;

  assign wrap       = (cnt == CNT_LAST);
  assign last_digit = (idx == IDX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      idx <= '0;
    end else if (wrap) begin
      cnt <= '0;
      idx <= last_digit ? '0 : idx + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign an_n  = ~(NUM_DIGITS'(1) << idx);
  assign seg_n = ~digit_codes[idx];

  AST_ONE_ANODE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~an_n) == 1); // R6
  AST_HOLD_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(an_n)); // R6
  AST_STEP_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !last_digit) |=> ((~an_n) == ($past(~an_n) << 1))); // R6
  AST_WRAP_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && last_digit) |=> (an_n[0] == 1'b0)); // R6
endmodule

// File: rtl/signed_addsub_display.sv
module signed_addsub_display
  import addsub_pkg::*;
#(
  parameter int OP_W        = 3,
  parameter int NUM_DIGITS  = 4,
  parameter int REFRESH_DIV = 50_000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [OP_W-1:0]       op_a,
  input  logic [OP_W-1:0]       op_b,
  input  logic                  sub_mode,
  output logic [OP_W:0]         led_result,
  output logic                  led_ovf,
  output logic [NUM_DIGITS-1:0] an_n,
  output logic [6:0]            seg_n
);
  logic [OP_W-1:0]             a_eff;
  logic [OP_W-1:0]             sum_raw;
  logic                        ovf;
  logic [OP_W:0]               result;
  logic [NUM_DIGITS-1:0][6:0]  digit_codes;
  logic                        is_neg;

  addsub_core #(.W(OP_W)) u_core (
    .op_a(op_a), .op_b(op_b), .sub_mode(sub_mode),
    .a_eff(a_eff), .sum_raw(sum_raw), .ovf(ovf), .result(result)
  );

  dec_display_map #(.W(OP_W), .NUM_DIGITS(NUM_DIGITS)) u_map (
    .result(result), .digit_codes(digit_codes), .is_neg(is_neg)
  );

  scan_driver #(.NUM_DIGITS(NUM_DIGITS), .REFRESH_DIV(REFRESH_DIV)) u_scan (
    .clk(clk), .rst_n(rst_n), .digit_codes(digit_codes),
    .an_n(an_n), .seg_n(seg_n)
  );

  assign led_result = result;
  assign led_ovf    = ovf;

  AST_EXACT_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_mode |-> ($signed(led_result) ==
      $signed({op_b[OP_W-1], op_b}) + $signed({op_a[OP_W-1], op_a}))); // R1
  AST_EXACT_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    sub_mode |-> ($signed(led_result) ==
      $signed({op_b[OP_W-1], op_b}) - $signed({op_a[OP_W-1], op_a}))); // R2
  AST_OVF_SIGNS: assert property (@(posedge clk) disable iff (!rst_n)
    led_ovf |-> (a_eff[OP_W-1] == op_b[OP_W-1] && sum_raw[OP_W-1] != op_b[OP_W-1])); // R3
  AST_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    led_result[OP_W] == (led_ovf ^ sum_raw[OP_W-1])); // R4
  AST_MINUS_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_n == ~SEG_MINUS) |-> is_neg); // R8
endmodule

// File: tb/signed_addsub_display_tb_top.sv
module signed_addsub_display_tb_top;
  localparam int DIV  = 2;
  localparam int ND   = 4;
  localparam int HOLD = DIV * ND * 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_a = '0;
  logic [2:0] op_b = '0;
  logic       sub_mode = 1'b0;
  logic [3:0] led_result;
  logic       led_ovf;
  logic [3:0] an_n;
  logic [6:0] seg_n;

  int total = 0;
  int bad   = 0;
  bit checking = 0;
  bit done = 0;
  int exp_val = 0;

  int m_cnt = 0;
  int m_idx = 0;

  always #10 clk = ~clk;  // 50 MHz

  signed_addsub_display #(.OP_W(3), .NUM_DIGITS(ND), .REFRESH_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sub_mode(sub_mode),
    .led_result(led_result), .led_ovf(led_ovf), .an_n(an_n), .seg_n(seg_n)
  );

  // Behavioural scan model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0;
      m_idx <= 0;
    end else if (m_cnt == DIV - 1) begin
      m_cnt <= 0;
      m_idx <= (m_idx + 1) % ND;
    end else begin
      m_cnt <= m_cnt + 1;
    end
  end

  function automatic logic [6:0] glyph(input int d);
    case (d)
      0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
      4: return 7'h19; 5: return 7'h12; 6: return 7'h02; 7: return 7'h78;
      8: return 7'h00; default: return 7'h10;
    endcase
  endfunction

  function automatic logic [6:0] exp_seg(input int v, input int k);
    int mag;
    mag = (v < 0) ? -v : v;
    if (k == 0) return glyph(mag % 10);
    if (k == 1) begin
      if (mag >= 10) return glyph((mag / 10) % 10);
      if (v < 0) return 7'h3F;
    end
    return 7'h7F;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (a=%0d b=%0d sub=%0b)",
               tag, act, expv, $signed(op_a), $signed(op_b), sub_mode);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      logic [3:0] an_exp;
      logic [6:0] s_exp;
      bit         o_exp;
      an_exp = ~(4'b0001 << m_idx);
      s_exp  = exp_seg(exp_val, m_idx);
      o_exp  = (exp_val > 3) || (exp_val < -4);
      check(led_result == 4'(exp_val), o_exp ? "R4" : (sub_mode ? "R2" : "R1"),
            led_result, 4'(exp_val));
      check(led_ovf == o_exp, "R3", led_ovf, o_exp);
      check(an_n == an_exp, "R6", an_n, an_exp);
      if (m_idx == 0)
        check(seg_n == s_exp, "R7", seg_n, s_exp);
      else if (s_exp == 7'h3F)
        check(seg_n == s_exp, "R8", seg_n, s_exp);
      else
        check(seg_n == s_exp, "R9", seg_n, s_exp);
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(an_n == 4'b1110, "R5", an_n, 4'b1110);
    check(m_idx == 0 && an_n[0] == 1'b0, "R5", an_n, 4'b1110);
    @(posedge clk); #2;
    rst_n = 1'b1;
    for (int md = 0; md < 2; md++) begin
      for (int ai = -4; ai < 4; ai++) begin
        for (int bi = -4; bi < 4; bi++) begin
          @(posedge clk); #2;
          checking = 1'b0;
          sub_mode = md[0];
          op_a     = 3'(ai);
          op_b     = 3'(bi);
          exp_val  = md[0] ? (bi - ai) : (bi + ai);
          checking = 1'b1;
          repeat (HOLD) @(posedge clk);
        end
      end
    end
    @(posedge clk); #2;
    checking = 1'b0;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule